// File: doc/BRIEF.md
# Clock-Sampled Asynchronous Static RAM Model

This block is a behavioural stand-in for a byte-wide asynchronous static RAM. It is meant to sit at the far end of a memory controller under test. A model clock samples its four control inputs, its address and its write data. There are two active-low controls, one for selecting the part and one for requesting a write. There is an active-high enable, and an active-low output gate. From the sampled levels the model decodes the operating mode, reads and writes its byte array, and drives a split data bus: `dq_out` carries the data and `dq_oe` stands in for the pad driver being turned on.

A write is in progress for as long as the write request and the select are both low and the enable is high. Whichever of the three leaves its active level first ends the write. The byte is committed at the sample where the write condition is first seen false, using the address and data of the sample just before. The address and data may therefore change right up to the ending edge. A write condition that stays true while the address moves means the controller skipped the toggle that must separate back-to-back writes. The model flags that case on `proto_err`.

With `ADDR_W = 15` and `DATA_W = 8` the array is the full 32,768 x 8 part. The defaults select a smaller array so that the model stays cheap to elaborate.

Top module: `async_sram_model`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits (32,768 x 8 when ADDR_W = 15), and a byte written at any address, including address 0 and the highest address, reads back unchanged.
- R2: Outputs reflect the inputs sampled at the previous rising clock edge. When that sample has sel_n = 0, en = 1, wen_n = 1 and oen_n = 0, then dq_oe is 1 and dq_out is the byte stored at the sampled address.
- R3: When the sample has wen_n = 0, sel_n = 0 and en = 1 (write mode), dq_oe is 0 whatever the level of oen_n.
- R4: When the sample has sel_n = 1 (deselected) or en = 0 (disabled), dq_oe is 0 and no byte is stored, even with wen_n = 0.
- R5: When the sample has oen_n = 1, dq_oe is 0 regardless of the other three controls.
- R6: A write is committed when the write condition ends, whether wen_n rises, sel_n rises or en falls. The committed address and data are those of the last sample in which the condition held, so the last data presented during the write wins.
- R7: If the write condition holds in two consecutive samples whose addresses differ, proto_err is 1 for exactly one cycle after the second sample. Only the final address of that write is stored, and the address held before the change keeps its old contents.
- R8: An address change while the part stays in read mode returns the byte at the new address on the next cycle.
- R9: dq_out is all zeros whenever dq_oe is 0.
- R10: While rst is high and in the first cycle after it, dq_oe and proto_err are 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Select, active low |
| wen_n | input | 1 | Write request, active low |
| en | input | 1 | Enable, active high |
| oen_n | input | 1 | Output gate, active low |
| addr | input | ADDR_W | Word address |
| dq_in | input | DATA_W | Write data from the controller |
| dq_out | output | DATA_W | Read data toward the controller, zero when not driven |
| dq_oe | output | 1 | High when the model drives the data bus |
| proto_err | output | 1 | One-cycle pulse when a held write changes address |

## Verification
The bench builds the model with ADDR_W = 11 and DATA_W = 8. This keeps the array small while still reaching address 0 and the top address 2047, which exercises the same decode path that the full-size part uses. With byte-wide data, each pattern written can be distinguished from both its neighbours and the previous contents. This makes it visible when a write lands at the wrong address or is wrongly dropped. Each of the three write-ending controls is driven in turn, as is a continuous write that hops addresses, against a bench-held copy of the array.

// File: rtl/sram_model_pkg.sv
package sram_model_pkg;

    typedef enum logic [2:0] {
        MODE_DESELECTED = 3'd0,
        MODE_DISABLED   = 3'd1,
        MODE_WRITE      = 3'd2,
        MODE_READ       = 3'd3,
        MODE_OUTPUT_OFF = 3'd4
    } sram_mode_e;

    typedef struct packed {
        logic sel_n;
        logic wen_n;
        logic en;
        logic oen_n;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{sel_n: 1'b1, wen_n: 1'b1, en: 1'b0, oen_n: 1'b1};

    function automatic logic write_active(input ctrl_t c);
        return !c.wen_n && !c.sel_n && c.en;
    endfunction

    function automatic sram_mode_e decode_mode(input ctrl_t c);
        if (c.sel_n)        return MODE_DESELECTED;
        else if (!c.en)     return MODE_DISABLED;
        else if (!c.wen_n)  return MODE_WRITE;
        else if (!c.oen_n)  return MODE_READ;
        else                return MODE_OUTPUT_OFF;
    endfunction

endpackage

// File: rtl/sram_ctrl_sampler.sv
module sram_ctrl_sampler
    import sram_model_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output ctrl_t             ctrl_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= CTRL_IDLE;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            ctrl_q <= ctrl_in;
            addr_q <= addr_in;
            data_q <= data_in;
        end
    end

endmodule

// File: rtl/sram_write_tracker.sv
module sram_write_tracker
    import sram_model_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl_now,
    input  ctrl_t             ctrl_q,
    input  logic [ADDR_W-1:0] addr_now,
    input  logic [ADDR_W-1:0] addr_q,
    output logic              commit,
    output logic              proto_err
);

    logic wr_now;
    logic wr_held;
    logic addr_moved;

    always_comb begin
        wr_now     = write_active(ctrl_now);
        wr_held    = write_active(ctrl_q);
        addr_moved = (addr_now != addr_q);
        // the write ends at the first sample where its condition is false
        commit     = wr_held && !wr_now;
    end

    always_ff @(posedge clk) begin
        if (rst) proto_err <= 1'b0;
        else     proto_err <= wr_held && wr_now && addr_moved;
    end

    // R7: a flagged error implies a write was in progress at the prior sample
    p_err_needs_write_r7: assert property (@(posedge clk) disable iff (rst)
        proto_err |-> $past(write_active(ctrl_q)));

    // R7: the error never stays up two cycles unless the write is still held
    p_err_one_shot_r7: assert property (@(posedge clk) disable iff (rst)
        (proto_err && !write_active(ctrl_q)) |=> !proto_err);

endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

    // R6: a committed byte is present at its address after the edge
    p_commit_lands_r6: assert property (@(posedge clk) disable iff (rst)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/async_sram_model.sv
module async_sram_model
    import sram_model_pkg::*;
#(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              wen_n,
    input  logic              en,
    input  logic              oen_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] dq_out,
    output logic              dq_oe,
    output logic              proto_err
);

    ctrl_t             ctrl_now;
    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic              commit;
    logic [DATA_W-1:0] rdata;
    sram_mode_e        mode_q;

    assign ctrl_now = '{sel_n: sel_n, wen_n: wen_n, en: en, oen_n: oen_n};

    sram_ctrl_sampler #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_sampler (
        .clk     (clk),
        .rst     (rst),
        .ctrl_in (ctrl_now),
        .addr_in (addr),
        .data_in (dq_in),
        .ctrl_q  (ctrl_q),
        .addr_q  (addr_q),
        .data_q  (data_q)
    );

    sram_write_tracker #(.ADDR_W(ADDR_W)) u_tracker (
        .clk       (clk),
        .rst       (rst),
        .ctrl_now  (ctrl_now),
        .ctrl_q    (ctrl_q),
        .addr_now  (addr),
        .addr_q    (addr_q),
        .commit    (commit),
        .proto_err (proto_err)
    );

    sram_byte_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
        .clk   (clk),
        .rst   (rst),
        .we    (commit),
        .waddr (addr_q),
        .wdata (data_q),
        .raddr (addr_q),
        .rdata (rdata)
    );

    always_comb begin
        mode_q = decode_mode(ctrl_q);
        dq_oe  = (mode_q == MODE_READ);
        dq_out = dq_oe ? rdata : '0;
    end

    // R2: a sampled read request turns the driver on
    p_read_drives_r2: assert property (@(posedge clk) disable iff (rst)
        $past(!sel_n && en && wen_n && !oen_n) |-> dq_oe);

    // R3: a sampled write keeps the bus released
    p_write_hiz_r3: assert property (@(posedge clk) disable iff (rst)
        $past(!sel_n && en && !wen_n) |-> !dq_oe);

    // R4: deselected or disabled keeps the bus released
    p_inactive_hiz_r4: assert property (@(posedge clk) disable iff (rst)
        $past(sel_n || !en) |-> !dq_oe);

    // R5: the output gate alone is enough to release the bus
    p_gate_hiz_r5: assert property (@(posedge clk) disable iff (rst)
        $past(oen_n) |-> !dq_oe);

    // R9: no data leaks out while the driver is off
    p_zero_when_off_r9: assert property (@(posedge clk) disable iff (rst)
        !dq_oe |-> (dq_out == '0));

endmodule

// File: tb/async_sram_model_test.sv
module async_sram_model_test;

    localparam int AW = 11;
    localparam int DW = 8;
    localparam logic [AW-1:0] TOP_ADDR = AW'((1 << AW) - 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sel_n = 1'b1;
    logic          wen_n = 1'b1;
    logic          en = 1'b0;
    logic          oen_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq_in = '0;
    logic [DW-1:0] dq_out;
    logic          dq_oe;
    logic          proto_err;

    int n_chk = 0;
    int n_fail = 0;
    logic [DW-1:0] model [1 << AW];

    always #10 clk = ~clk;

    async_sram_model #(.ADDR_W(AW), .DATA_W(DW)) uut (
        .clk(clk), .rst(rst), .sel_n(sel_n), .wen_n(wen_n), .en(en),
        .oen_n(oen_n), .addr(addr), .dq_in(dq_in), .dq_out(dq_out),
        .dq_oe(dq_oe), .proto_err(proto_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drive at a falling edge, return at the next falling edge
    task automatic apply(input logic s, input logic w, input logic e, input logic o,
                         input logic [AW-1:0] a, input logic [DW-1:0] d);
        sel_n = s; wen_n = w; en = e; oen_n = o; addr = a; dq_in = d;
        @(negedge clk);
    endtask

    task automatic off_checks(input string req);
        chk({req, " dq_oe"}, 32'(dq_oe), 32'd0);
        chk({"R9 via ", req}, 32'(dq_out), 32'd0);
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        apply(1'b0, 1'b0, 1'b1, 1'b1, a, d);
        apply(1'b0, 1'b1, 1'b1, 1'b1, a, d);
        model[a] = d;
    endtask

    task automatic do_read(input string req, input logic [AW-1:0] a);
        apply(1'b0, 1'b1, 1'b1, 1'b0, a, 8'h00);
        chk({req, " oe"}, 32'(dq_oe), 32'd1);
        chk({req, " data"}, 32'(dq_out), 32'(model[a]));
    endtask

    task automatic t_reset_r10;
        repeat (3) @(negedge clk);
        chk("R10 oe in reset", 32'(dq_oe), 32'd0);
        chk("R10 err in reset", 32'(proto_err), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R10 oe after reset", 32'(dq_oe), 32'd0);
        chk("R10 err after reset", 32'(proto_err), 32'd0);
    endtask

    task automatic t_extremes_r1;
        do_write('0, 8'h5A);
        do_write(TOP_ADDR, 8'hA5);
        do_write(AW'(300), 8'h3C);
        do_read("R1 addr0", '0);
        do_read("R1 top", TOP_ADDR);
        do_read("R2 mid", AW'(300));
    endtask

    task automatic t_write_ignores_gate_r3;
        apply(1'b0, 1'b0, 1'b1, 1'b0, AW'(17), 8'hC3);
        off_checks("R3 write with oen_n low");
        apply(1'b0, 1'b1, 1'b1, 1'b1, AW'(17), 8'hC3);
        model[17] = 8'hC3;
        do_read("R3 readback", AW'(17));
    endtask

    task automatic t_inactive_r4;
        do_write(AW'(40), 8'h11);
        apply(1'b1, 1'b0, 1'b1, 1'b0, AW'(40), 8'hEE);
        off_checks("R4 deselected");
        apply(1'b0, 1'b0, 1'b0, 1'b0, AW'(40), 8'hDD);
        off_checks("R4 disabled");
        apply(1'b1, 1'b1, 1'b0, 1'b1, AW'(40), 8'h00);
        do_read("R4 no store", AW'(40));
    endtask

    task automatic t_gate_r5;
        apply(1'b0, 1'b1, 1'b1, 1'b1, AW'(300), 8'h00);
        off_checks("R5 gate high");
    endtask

    task automatic t_end_controls_r6;
        // ended by select rising
        apply(1'b0, 1'b0, 1'b1, 1'b1, AW'(60), 8'h61);
        apply(1'b1, 1'b0, 1'b1, 1'b1, AW'(60), 8'h61);
        model[60] = 8'h61;
        // wen_n still low, a new write starts cleanly after the select toggle
        apply(1'b0, 1'b0, 1'b1, 1'b1, AW'(61), 8'h71);
        chk("R7 no error after toggle", 32'(proto_err), 32'd0);
        // ended by enable falling
        apply(1'b0, 1'b0, 1'b0, 1'b1, AW'(61), 8'h71);
        model[61] = 8'h71;
        do_read("R6 end by select", AW'(60));
        do_read("R6 end by enable", AW'(61));
        // last data wins
        apply(1'b0, 1'b0, 1'b1, 1'b1, AW'(62), 8'h01);
        apply(1'b0, 1'b0, 1'b1, 1'b1, AW'(62), 8'h02);
        apply(1'b0, 1'b0, 1'b1, 1'b1, AW'(62), 8'h93);
        apply(1'b0, 1'b1, 1'b1, 1'b1, AW'(62), 8'h00);
        model[62] = 8'h93;
        do_read("R6 last data", AW'(62));
    endtask

    task automatic t_held_write_r7;
        do_write(AW'(80), 8'h80);
        do_write(AW'(81), 8'h81);
        apply(1'b0, 1'b0, 1'b1, 1'b1, AW'(80), 8'hF0);
        chk("R7 no error yet", 32'(proto_err), 32'd0);
        apply(1'b0, 1'b0, 1'b1, 1'b1, AW'(81), 8'hF1);
        chk("R7 error pulse", 32'(proto_err), 32'd1);
        apply(1'b0, 1'b0, 1'b1, 1'b1, AW'(81), 8'hF1);
        chk("R7 pulse width", 32'(proto_err), 32'd0);
        apply(1'b0, 1'b1, 1'b1, 1'b1, AW'(81), 8'hF1);
        model[81] = 8'hF1;
        do_read("R7 old address kept", AW'(80));
        do_read("R7 final address stored", AW'(81));
    endtask

    task automatic t_addr_walk_r8;
        do_read("R8 first", AW'(60));
        do_read("R8 next", AW'(61));
        do_read("R8 top", TOP_ADDR);
    endtask

    initial begin
        @(negedge clk);
        t_reset_r10();
        t_extremes_r1();
        t_write_ignores_gate_r3();
        t_inactive_r4();
        t_gate_r5();
        t_end_controls_r6();
        t_held_write_r7();
        t_addr_walk_r8();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule